// File: doc/BRIEF.md
# Timestamp Queue Readout Controller

The block holds two queues of 64-bit timestamps, one for received frames and one for transmitted frames. Upstream logic pushes entries; a processor drains them one at a time through a 4-bit control word. Per queue the word has a flush bit and a fetch bit. Raising a fetch bit moves the oldest entry of that queue into a holding register and sets a sticky ready flag. Software polls the flag, then reads the held entry as an upper and a lower 32-bit word.

Each queue also has a 32-bit status word that gives its occupancy. A driver works like this: write the control word to zero, set one fetch bit, poll until the matching ready flag is set, read the two data words, and repeat once for each counted entry. Address decoding and the logic that fills the queues sit outside this block.

Top module: `ts_queue_ctrl`

## Requirements
- R1: Writing the control word stores all four bits. Bits 3 (receive flush) and 1 (transmit flush) read back as written. On readback, bit 2 shows the receive ready flag and bit 0 shows the transmit ready flag.
- R2: Each status word carries the queue's entry count in bits 7:0, and bits 31:8 read zero. An accepted push raises the count by one at the next clock edge.
- R3: A 0-to-1 change of a queue's fetch bit, seen by the block one cycle after the control write, pops the oldest entry at the next edge. At that edge the entry's bits 63:32 appear on the high word, bits 31:0 appear on the low word, the ready flag goes to 1 and the count drops by one.
- R4: Entries leave each queue in the order they were pushed, and the two queues are independent.
- R5: Holding a fetch bit at 1 pops nothing further. The ready flag and the held entry stay unchanged.
- R6: Once the fetch bit reads 0 in the control register, the ready flag is 0 after the next edge.
- R7: A fetch edge on an empty queue pops nothing, leaves the ready flag at 0 and leaves the held entry unchanged.
- R8: While a queue's flush bit is 1, that queue is emptied each cycle: its count is 0, its ready flag is 0, its held entry is zero and pushes are dropped. The other queue is not affected.
- R9: A push and a pop at the same edge leave the count unchanged.
- R10: A push to a full queue (DEPTH entries) is dropped, and the count stays at DEPTH.
- R11: Asynchronous reset clears the control word, both queues, both ready flags and both held entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_wr_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 4 | Control word write data |
| ctrl_rdata_o | output | 4 | Control word readback, with ready flags |
| rx_push_i | input | 1 | Push into the receive queue |
| rx_stamp_i | input | 64 | Receive timestamp to push |
| tx_push_i | input | 1 | Push into the transmit queue |
| tx_stamp_i | input | 64 | Transmit timestamp to push |
| rx_status_o | output | 32 | Receive queue count status |
| tx_status_o | output | 32 | Transmit queue count status |
| rx_data_hi_o | output | 32 | Held receive entry, bits 63:32 |
| rx_data_lo_o | output | 32 | Held receive entry, bits 31:0 |
| tx_data_hi_o | output | 32 | Held transmit entry, bits 63:32 |
| tx_data_lo_o | output | 32 | Held transmit entry, bits 31:0 |

## Verification
The assertions take for granted that DEPTH is below 256, so the count fits the 8-bit status field. They also assume the push strobes are plain single-cycle levels with no handshake back, so overflow is handled only by dropping. The stimulus follows the driver sequence: it clears the control word before each fetch and holds the fetch bit for several cycles. It also departs from that sequence on purpose, to fetch from an empty queue, overfill a queue, push into a queue that is being flushed, and push at the same edge as a pop.

// File: rtl/ts_pkg.sv
package ts_pkg;
  localparam int STAMP_W     = 64;
  localparam int WORD_W      = 32;
  localparam int CNT_FIELD_W = 8;
  localparam int CTRL_W      = 4;
  localparam int N_LANES     = 2;
  // lane 1 = receive, lane 0 = transmit; flush bit = 2*lane+1, fetch bit = 2*lane
  localparam int LANE_RX = 1;
  localparam int LANE_TX = 0;
endpackage

// File: rtl/ts_fifo.sv
module ts_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 64,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [W-1:0]     data_i,
  input  logic             pop_i,
  output logic [W-1:0]     head_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             push_ok, pop_ok;

  assign push_ok = push_i && !flush_i && (count_o != FULL_CNT);
  assign pop_ok  = pop_i  && !flush_i && (count_o != '0);
  assign head_o  = mem[rd_ptr];

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_o <= '0;
    end else if (flush_i) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_o <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count_o <= count_o + 1'b1;
        2'b01:   count_o <= count_o - 1'b1;
        default: count_o <= count_o;
      endcase
    end
  end

  // R10
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= FULL_CNT);
  // R10
  full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == FULL_CNT && push_i && !pop_i && !flush_i) |=> count_o == FULL_CNT);
  // R9
  push_pop_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !flush_i && count_o != '0 && count_o != FULL_CNT) |=> $stable(count_o));
  // R7
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && count_o == '0) |=> count_o == '0);
endmodule

// File: rtl/ts_lane.sv
module ts_lane #(
  parameter int DEPTH = 16,
  localparam int W     = ts_pkg::STAMP_W,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             req_i,
  input  logic             push_i,
  input  logic [W-1:0]     stamp_i,
  output logic             ready_o,
  output logic [W-1:0]     hold_o,
  output logic [CNT_W-1:0] count_o
);
  logic         req_d;
  logic         pop;
  logic [W-1:0] head;

  assign pop = req_i && !req_d && !flush_i && (count_o != '0);

  ts_fifo #(.DEPTH(DEPTH), .W(W)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush_i),
    .push_i  (push_i),
    .data_i  (stamp_i),
    .pop_i   (pop),
    .head_o  (head),
    .count_o (count_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_d   <= 1'b0;
      ready_o <= 1'b0;
      hold_o  <= '0;
    end else begin
      req_d <= req_i;
      if (flush_i) begin
        ready_o <= 1'b0;
        hold_o  <= '0;
      end else if (pop) begin
        ready_o <= 1'b1;
        hold_o  <= head;
      end else if (!req_i) begin
        ready_o <= 1'b0;
      end
    end
  end

  // R3
  ready_needs_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(count_o) != '0);
  // R6
  ready_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !ready_o);
  // R5
  held_req_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && $past(req_i) && !flush_i) |=> $stable(hold_o));
  // R8
  flush_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (count_o == '0 && !ready_o && hold_o == '0));
endmodule

// File: rtl/ts_queue_ctrl.sv
module ts_queue_ctrl #(
  parameter int DEPTH = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ctrl_wr_i,
  input  logic [3:0]  ctrl_wdata_i,
  output logic [3:0]  ctrl_rdata_o,
  input  logic        rx_push_i,
  input  logic [63:0] rx_stamp_i,
  input  logic        tx_push_i,
  input  logic [63:0] tx_stamp_i,
  output logic [31:0] rx_status_o,
  output logic [31:0] tx_status_o,
  output logic [31:0] rx_data_hi_o,
  output logic [31:0] rx_data_lo_o,
  output logic [31:0] tx_data_hi_o,
  output logic [31:0] tx_data_lo_o
);
  import ts_pkg::*;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CTRL_W-1:0]  ctrl_q;
  logic [N_LANES-1:0] push, ready;
  logic [STAMP_W-1:0] stamp [N_LANES];
  logic [STAMP_W-1:0] hold  [N_LANES];
  logic [CNT_W-1:0]   count [N_LANES];
  logic [WORD_W-1:0]  status [N_LANES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= '0;
    else if (ctrl_wr_i) ctrl_q <= ctrl_wdata_i;
  end

  assign push[LANE_RX]  = rx_push_i;
  assign push[LANE_TX]  = tx_push_i;
  assign stamp[LANE_RX] = rx_stamp_i;
  assign stamp[LANE_TX] = tx_stamp_i;

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    ts_lane #(.DEPTH(DEPTH)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .flush_i (ctrl_q[2*g+1]),
      .req_i   (ctrl_q[2*g]),
      .push_i  (push[g]),
      .stamp_i (stamp[g]),
      .ready_o (ready[g]),
      .hold_o  (hold[g]),
      .count_o (count[g])
    );
    assign status[g] = {{(WORD_W-CNT_FIELD_W){1'b0}}, CNT_FIELD_W'(count[g])};
    assign ctrl_rdata_o[2*g+1] = ctrl_q[2*g+1];
    assign ctrl_rdata_o[2*g]   = ready[g];
  end

  assign rx_status_o  = status[LANE_RX];
  assign tx_status_o  = status[LANE_TX];
  assign rx_data_hi_o = hold[LANE_RX][STAMP_W-1:WORD_W];
  assign rx_data_lo_o = hold[LANE_RX][WORD_W-1:0];
  assign tx_data_hi_o = hold[LANE_TX][STAMP_W-1:WORD_W];
  assign tx_data_lo_o = hold[LANE_TX][WORD_W-1:0];

  // R2
  status_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_status_o[31:8] == '0 && tx_status_o[31:8] == '0);
  // R1
  flush_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i |=> (ctrl_rdata_o[3] == $past(ctrl_wdata_i[3]) && ctrl_rdata_o[1] == $past(ctrl_wdata_i[1])));
endmodule

// File: tb/ts_queue_ctrl_test.sv
module ts_queue_ctrl_test;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_wr = 1'b0;
  logic [3:0]  ctrl_wdata = '0;
  logic [3:0]  ctrl_rdata;
  logic        rx_push = 1'b0, tx_push = 1'b0;
  logic [63:0] rx_stamp = '0, tx_stamp = '0;
  logic [31:0] rx_status, tx_status, rx_hi, rx_lo, tx_hi, tx_lo;

  int    n_chk = 0;
  int    n_fail = 0;
  string phase = "R11 reset";

  always #5 clk = ~clk;

  ts_queue_ctrl #(.DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .ctrl_wr_i(ctrl_wr), .ctrl_wdata_i(ctrl_wdata), .ctrl_rdata_o(ctrl_rdata),
    .rx_push_i(rx_push), .rx_stamp_i(rx_stamp),
    .tx_push_i(tx_push), .tx_stamp_i(tx_stamp),
    .rx_status_o(rx_status), .tx_status_o(tx_status),
    .rx_data_hi_o(rx_hi), .rx_data_lo_o(rx_lo),
    .tx_data_hi_o(tx_hi), .tx_data_lo_o(tx_lo)
  );

  // reference model: index 1 = receive, 0 = transmit
  logic [3:0]  m_ctrl;
  bit          m_prev [2];
  bit          m_rdy  [2];
  logic [63:0] m_hold [2];
  logic [63:0] q_rx [$];
  logic [63:0] q_tx [$];

  task automatic lane_step(input int l, input bit push, input logic [63:0] d,
                           ref logic [63:0] q [$]);
    bit flush = m_ctrl[2*l+1];
    bit req   = m_ctrl[2*l];
    int size0 = q.size();
    if (flush) begin
      q.delete();
      m_rdy[l]  = 0;
      m_hold[l] = '0;
    end else begin
      if (req && !m_prev[l] && size0 > 0) begin
        m_hold[l] = q.pop_front();
        m_rdy[l]  = 1;
      end else if (!req) m_rdy[l] = 0;
      if (push && size0 < DEPTH) q.push_back(d);
    end
    m_prev[l] = req;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = '0;
      for (int l = 0; l < 2; l++) begin
        m_prev[l] = 0; m_rdy[l] = 0; m_hold[l] = '0;
      end
      q_rx.delete(); q_tx.delete();
    end else begin
      lane_step(1, rx_push, rx_stamp, q_rx);
      lane_step(0, tx_push, tx_stamp, q_tx);
      if (ctrl_wr) m_ctrl = ctrl_wdata;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s [%s] at %0t: actual %h expected %h", req, phase, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    chk("R1", {28'd0, ctrl_rdata}, {28'd0, m_ctrl[3], m_rdy[1], m_ctrl[1], m_rdy[0]});
    chk("R2", rx_status, 32'(q_rx.size()));
    chk("R2", tx_status, 32'(q_tx.size()));
    chk("R3", rx_hi, m_hold[1][63:32]);
    chk("R3", rx_lo, m_hold[1][31:0]);
    chk("R3", tx_hi, m_hold[0][63:32]);
    chk("R3", tx_lo, m_hold[0][31:0]);
  end

  task automatic wr_ctrl(input logic [3:0] v);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = v;
    @(negedge clk); ctrl_wr = 1'b0;
  endtask

  task automatic push_rx(input logic [63:0] d);
    @(negedge clk); rx_push = 1'b1; rx_stamp = d;
    @(negedge clk); rx_push = 1'b0;
  endtask

  task automatic push_tx(input logic [63:0] d);
    @(negedge clk); tx_push = 1'b1; tx_stamp = d;
    @(negedge clk); tx_push = 1'b0;
  endtask

  // driver sequence: clear, set fetch bit, poll ready, hold a few cycles
  task automatic fetch(input int l);
    wr_ctrl(4'd0);
    wr_ctrl(4'(1 << (2*l)));
    for (int i = 0; i < 6; i++) begin
      if (ctrl_rdata[2*l]) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R11: reset state checked by the per-cycle compare
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    phase = "R2 push count";
    for (int i = 0; i < 3; i++) push_rx({32'hA000_0000 + i, 32'h0000_1000 + i});
    for (int i = 0; i < 2; i++) push_tx({32'hB000_0000 + i, 32'h0000_2000 + i});

    phase = "R3 R4 R5 R6 ordered fetch";
    fetch(1); fetch(0); fetch(1); fetch(1); fetch(0);
    wr_ctrl(4'd0);
    repeat (2) @(negedge clk);

    phase = "R7 fetch on empty";
    fetch(0);
    fetch(1);
    wr_ctrl(4'd0);

    phase = "R9 push with pop";
    push_rx(64'hC0C0_0001_0000_0001);
    push_rx(64'hC0C0_0002_0000_0002);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = 4'h4;
    @(negedge clk); ctrl_wr = 1'b0; rx_push = 1'b1; rx_stamp = 64'hC0C0_0003_0000_0003;
    @(negedge clk); rx_push = 1'b0;
    repeat (3) @(negedge clk);
    wr_ctrl(4'd0);

    phase = "R10 overfill";
    for (int i = 0; i < DEPTH + 4; i++) push_tx({32'hD000_0000 + i, 32'(i)});
    fetch(0);
    wr_ctrl(4'd0);

    phase = "R8 flush receive only";
    @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = 4'h8;
    @(negedge clk); ctrl_wr = 1'b0;
    push_rx(64'hEEEE_0000_EEEE_0001);
    fetch(0);
    wr_ctrl(4'h8);
    repeat (2) @(negedge clk);

    phase = "R1 flush bit readback";
    wr_ctrl(4'hA);
    wr_ctrl(4'hF);
    repeat (2) @(negedge clk);
    wr_ctrl(4'd0);
    push_rx(64'h1234_5678_9ABC_DEF0);
    fetch(1);
    wr_ctrl(4'd0);
    repeat (3) @(negedge clk);

    finish_run();
  end
endmodule